// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs whole flash operations on an 8-bit NAND pin interface for a device whose pages hold 2048 data bytes and 64 spare bytes. A host gives one request: an operation code, a row (page index), a column (byte within the page) and a byte count. The block then drives the command-latch, address-latch and data cycles on the pins. After a page read it waits for the array to load the page. After a program or an erase it polls the status byte until the device reports ready. When the operation ends it reports ok, fail or timeout.

Write data is pulled from the host one byte at a time with a ready strobe. Read data is pushed to the host with a valid strobe. Every pin cycle takes two clocks: a strobe-low phase and a strobe-high phase, so the device latches on the rising write strobe. A read cycle takes one more clock, in which the sampled byte is presented. The chip select is a host input, captured when a request is accepted. Column 2048 addresses the first spare byte, so the spare area is reached through an ordinary page read or program.

Top module: `nand_op_seq`

## Requirements
- R1: `busy` rises on the clock after a request is accepted (`reqValid` high, `busy` low, `reqOp` at most 4). It stays high until the cycle after the one-cycle `done` pulse. Requests that arrive while `busy` is high are ignored and do not change the pin sequence.
- R2: A command cycle holds `nandCle` high and `nandAle` low. An address cycle holds `nandAle` high and `nandCle` low. Both pins drop when the cycle ends, the two are never high together, and the byte is driven while `nandWeN` rises.
- R3: A page read (`reqOp`=1) sends command 0x00, then five address bytes, then command 0x30. The five address bytes are: column bits 7:0; then column bits 11:8 with the upper nibble zero; then row bits 7:0, 15:8 and 23:16. The first read strobe falls LOAD_CYCLES+1 clocks after the 0x30 latch edge. `reqLen` bytes (1 or more) then appear on `rdData` with `rdValid`, in column order.
- R4: A page program (`reqOp`=2) sends 0x80, then the same five address bytes, then `reqLen` data bytes (1 to 2112), then 0x10. Each data byte is taken from `wrData` in the cycle where `wrReady` is high. The block then polls status.
- R5: A block erase (`reqOp`=3) sends 0x60, then three row bytes with row bits 5:0 forced to zero, then 0xD0. It then polls status.
- R6: Status polling sends 0x70 once, then reads status bytes until bit 6 (ready) is 1. `result` is then 1 if bit 0 of that byte is 1, else 0.
- R7: If POLL_LIMIT status reads all show bit 6 clear, the operation ends with `result` = 2 and no further read.
- R8: Read ID (`reqOp`=0) sends 0x90, then one address byte of 0x00, then reads 5 bytes out on `rdData`, with `result` 0.
- R9: Read status (`reqOp`=4) sends 0x70, reads one byte and presents it on `rdData`, with `result` 0.
- R10: `nandWeN` and `nandReN` are never low together, and `nandIoOe` is low whenever `nandReN` is low.
- R11: After reset, `nandWeN`, `nandReN` and `nandCeN` are high, `nandCle`, `nandAle`, `nandIoOe` and `busy` are low.
- R12: `nandCeN` is low only while `busy` is high, and only if `chipSel` was 1 when the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 3 | 0 ID, 1 read, 2 program, 3 erase, 4 status |
| reqRow | input | 24 | Page index |
| reqCol | input | 12 | Byte column within the page |
| reqLen | input | 12 | Data byte count for read and program |
| chipSel | input | 1 | Select the device for this request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |
| result | output | 2 | 0 ok, 1 fail, 2 timeout |
| wrData | input | 8 | Program data byte |
| wrReady | output | 1 | `wrData` consumed this cycle |
| rdData | output | 8 | Read data byte |
| rdValid | output | 1 | `rdData` valid |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandIoOut | output | 8 | Byte driven onto the I/O bus |
| nandIoOe | output | 1 | I/O output enable |
| nandIoIn | input | 8 | Byte read from the I/O bus |

## Verification
The bound checker watches the pin-level rules on every cycle. It checks that CLE and ALE are never both high, that the two strobes never overlap, that the bus is not driven during a read strobe, and that a byte is driven at each rising write strobe. It also checks the handshake from accept through `busy` to `done`, that the chip enable stays high when idle, and that `result` never takes the unused code. The ordering of command, address and data bytes cannot be seen from one cycle, and neither can the page-bit masking for erase, the load delay, the poll count until ready or timeout, or the returned data. Only the bench scenarios show these. They run the bench's device model against expected byte logs and expected read data.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int COL_W = 12;
  localparam int ROW_W = 24;

  typedef enum logic [2:0] {
    OP_ID = 3'd0, OP_READ = 3'd1, OP_PROG = 3'd2, OP_ERASE = 3'd3, OP_STAT = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    BK_NONE, BK_CMD, BK_ADDR, BK_WDATA, BK_RDATA
  } busKind_e;

  // per-cycle strobes from control to datapath
  typedef struct packed {
    logic       cap;      // latch request fields
    busKind_e   kind;     // kind of pin cycle in progress
    logic       low;      // strobe-low phase
    logic       emit;     // read byte goes to host
    logic [7:0] cmd;      // command byte
    logic [2:0] addrIdx;  // address byte selector, 5 = constant zero
  } busStrobe_t;

  localparam logic [1:0] RES_OK      = 2'd0;
  localparam logic [1:0] RES_FAIL    = 2'd1;
  localparam logic [1:0] RES_TIMEOUT = 2'd2;

  localparam logic [7:0] CMD_READ1  = 8'h00;
  localparam logic [7:0] CMD_READ2  = 8'h30;
  localparam logic [7:0] CMD_PROG1  = 8'h80;
  localparam logic [7:0] CMD_PROG2  = 8'h10;
  localparam logic [7:0] CMD_ERASE1 = 8'h60;
  localparam logic [7:0] CMD_ERASE2 = 8'hD0;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] CMD_ID     = 8'h90;
endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int LEN_W       = 12,
  parameter int LOAD_CYCLES = 5000,
  parameter int POLL_LIMIT  = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             statReady,
  input  logic             statFail,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  output logic             wrReady,
  output busStrobe_t       stb
);
  localparam int WAIT_W = $clog2(LOAD_CYCLES + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_LOAD, S_SCMD, S_POLL, S_RDATA, S_DONE
  } state_e;

  state_e            state;
  op_e               op;
  logic [1:0]        ph;
  logic [2:0]        addrIdx;
  logic [LEN_W-1:0]  len, cnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [POLL_W-1:0] pollCnt;
  logic              accept;

  assign accept = reqValid && (reqOp <= 3'd4);
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_DONE);

  always_comb begin
    stb     = '0;
    wrReady = 1'b0;
    unique case (state)
      S_IDLE: stb.cap = accept;
      S_CMD1: begin
        stb.kind = BK_CMD;
        stb.low  = (ph == 2'd0);
        unique case (op)
          OP_ID:    stb.cmd = CMD_ID;
          OP_READ:  stb.cmd = CMD_READ1;
          OP_PROG:  stb.cmd = CMD_PROG1;
          OP_ERASE: stb.cmd = CMD_ERASE1;
          default:  stb.cmd = CMD_STATUS;
        endcase
      end
      S_CMD2: begin
        stb.kind = BK_CMD;
        stb.low  = (ph == 2'd0);
        unique case (op)
          OP_READ: stb.cmd = CMD_READ2;
          OP_PROG: stb.cmd = CMD_PROG2;
          default: stb.cmd = CMD_ERASE2;
        endcase
      end
      S_SCMD: begin
        stb.kind = BK_CMD;
        stb.low  = (ph == 2'd0);
        stb.cmd  = CMD_STATUS;
      end
      S_ADDR: begin
        stb.kind    = BK_ADDR;
        stb.low     = (ph == 2'd0);
        stb.addrIdx = (op == OP_ID) ? 3'd5 : addrIdx;
      end
      S_WDATA: begin
        stb.kind = BK_WDATA;
        stb.low  = (ph == 2'd0);
        wrReady  = (ph == 2'd0);
      end
      S_POLL, S_RDATA: begin
        if (ph != 2'd2) begin
          stb.kind = BK_RDATA;
          stb.low  = (ph == 2'd0);
          stb.emit = (state == S_RDATA);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      op      <= OP_STAT;
      ph      <= 2'd0;
      addrIdx <= 3'd0;
      len     <= '0;
      cnt     <= '0;
      waitCnt <= '0;
      pollCnt <= '0;
      result  <= RES_OK;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          op     <= op_e'(reqOp);
          len    <= reqLen;
          result <= RES_OK;
          ph     <= 2'd0;
          state  <= S_CMD1;
        end
        S_CMD1: if (ph == 2'd0) ph <= 2'd1;
        else begin
          ph <= 2'd0;
          unique case (op)
            OP_STAT:  begin cnt <= '0; state <= S_RDATA; end
            OP_ERASE: begin addrIdx <= 3'd2; state <= S_ADDR; end
            OP_ID:    begin addrIdx <= 3'd4; state <= S_ADDR; end
            default:  begin addrIdx <= 3'd0; state <= S_ADDR; end
          endcase
        end
        S_ADDR: if (ph == 2'd0) ph <= 2'd1;
        else begin
          ph <= 2'd0;
          if (addrIdx == 3'd4) begin
            unique case (op)
              OP_ID:   begin cnt <= LEN_W'(4); state <= S_RDATA; end
              OP_PROG: begin cnt <= len - 1'b1; state <= S_WDATA; end
              default: state <= S_CMD2;
            endcase
          end else addrIdx <= addrIdx + 3'd1;
        end
        S_WDATA: if (ph == 2'd0) ph <= 2'd1;
        else begin
          ph <= 2'd0;
          if (cnt == '0) state <= S_CMD2;
          else cnt <= cnt - 1'b1;
        end
        S_CMD2: if (ph == 2'd0) ph <= 2'd1;
        else begin
          ph <= 2'd0;
          if (op == OP_READ) begin waitCnt <= '0; state <= S_LOAD; end
          else state <= S_SCMD;
        end
        S_LOAD: if (waitCnt == WAIT_W'(LOAD_CYCLES - 1)) begin
          cnt   <= len - 1'b1;
          ph    <= 2'd0;
          state <= S_RDATA;
        end else waitCnt <= waitCnt + 1'b1;
        S_SCMD: if (ph == 2'd0) ph <= 2'd1;
        else begin
          ph      <= 2'd0;
          pollCnt <= '0;
          state   <= S_POLL;
        end
        S_POLL: if (ph != 2'd2) ph <= ph + 2'd1;
        else begin
          ph <= 2'd0;
          if (statReady) begin
            result <= statFail ? RES_FAIL : RES_OK;
            state  <= S_DONE;
          end else if (pollCnt == POLL_W'(POLL_LIMIT - 1)) begin
            result <= RES_TIMEOUT;
            state  <= S_DONE;
          end else pollCnt <= pollCnt + 1'b1;
        end
        S_RDATA: if (ph != 2'd2) ph <= ph + 2'd1;
        else begin
          ph <= 2'd0;
          if (cnt == '0) state <= S_DONE;
          else cnt <= cnt - 1'b1;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BITS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       stb,
  input  logic             busy,
  input  logic [2:0]       reqOp,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic             chipSel,
  input  logic [7:0]       wrData,
  input  logic [7:0]       ioIn,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             ceN,
  output logic             cle,
  output logic             ale,
  output logic             weN,
  output logic             reN,
  output logic [7:0]       ioOut,
  output logic             ioOe
);
  localparam logic [ROW_W-1:0] ROW_MASK = {{(ROW_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ;
  logic             selQ, emitQ, isWrite;
  logic [7:0]       addrByte;

  assign isWrite = (stb.kind == BK_CMD) || (stb.kind == BK_ADDR) || (stb.kind == BK_WDATA);
  assign ceN     = ~(busy && selQ);

  always_comb begin
    unique case (stb.addrIdx)
      3'd0:    addrByte = colQ[7:0];
      3'd1:    addrByte = {4'h0, colQ[11:8]};
      3'd2:    addrByte = rowQ[7:0];
      3'd3:    addrByte = rowQ[15:8];
      3'd4:    addrByte = rowQ[23:16];
      default: addrByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ <= '0; colQ <= '0; selQ <= 1'b0;
      cle <= 1'b0; ale <= 1'b0; weN <= 1'b1; reN <= 1'b1;
      ioOut <= 8'h00; ioOe <= 1'b0;
      emitQ <= 1'b0; rdData <= 8'h00; rdValid <= 1'b0;
    end else begin
      if (stb.cap) begin
        rowQ <= (reqOp == OP_ERASE) ? (reqRow & ROW_MASK) : reqRow;
        colQ <= reqCol;
        selQ <= chipSel;
      end
      cle   <= (stb.kind == BK_CMD);
      ale   <= (stb.kind == BK_ADDR);
      weN   <= ~(stb.low && isWrite);
      reN   <= ~(stb.low && (stb.kind == BK_RDATA));
      ioOe  <= isWrite;
      emitQ <= stb.emit;
      if (stb.kind == BK_CMD) ioOut <= stb.cmd;
      else if (stb.kind == BK_ADDR) ioOut <= addrByte;
      else if (stb.kind == BK_WDATA && stb.low) ioOut <= wrData;
      if (!reN) rdData <= ioIn;
      rdValid <= !reN && emitQ;
    end
  end
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_seq_pkg::*;
#(
  parameter int LEN_W       = 12,
  parameter int PAGE_BITS   = 6,
  parameter int LOAD_CYCLES = 5000,
  parameter int POLL_LIMIT  = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             chipSel,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  input  logic [7:0]       wrData,
  output logic             wrReady,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             nandCeN,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN,
  output logic [7:0]       nandIoOut,
  output logic             nandIoOe,
  input  logic [7:0]       nandIoIn
);
  busStrobe_t stb;

  nand_seq_ctrl #(.LEN_W(LEN_W), .LOAD_CYCLES(LOAD_CYCLES), .POLL_LIMIT(POLL_LIMIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqLen(reqLen),
    .statReady(rdData[6]), .statFail(rdData[0]),
    .busy(busy), .done(done), .result(result), .wrReady(wrReady), .stb(stb)
  );

  nand_seq_dp #(.PAGE_BITS(PAGE_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .reqOp(reqOp), .reqRow(reqRow),
    .reqCol(reqCol), .chipSel(chipSel), .wrData(wrData), .ioIn(nandIoIn),
    .rdData(rdData), .rdValid(rdValid), .ceN(nandCeN), .cle(nandCle), .ale(nandAle),
    .weN(nandWeN), .reN(nandReN), .ioOut(nandIoOut), .ioOe(nandIoOe)
  );
endmodule

// File: rtl/nand_op_seq_chk.sv
module nand_op_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [2:0] reqOp,
  input logic       busy,
  input logic       done,
  input logic [1:0] result,
  input logic       wrReady,
  input logic       rdValid,
  input logic       nandCeN,
  input logic       nandCle,
  input logic       nandAle,
  input logic       nandWeN,
  input logic       nandReN,
  input logic       nandIoOe
);
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && reqOp <= 3'd4) |=> busy);
  assert_done_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));
  assert_latch_driven_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> nandIoOe);
  assert_rdvalid_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> busy);
  assert_wrready_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> busy);
  assert_result_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result != 2'd3));
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));
  assert_no_drive_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandIoOe);
  assert_ce_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> nandCeN);
endmodule

bind nand_op_seq nand_op_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .busy(busy), .done(done),
  .result(result), .wrReady(wrReady), .rdValid(rdValid), .nandCeN(nandCeN),
  .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
  .nandIoOe(nandIoOe)
);

// File: tb/nand_op_seq_tb_top.sv
`timescale 1ns/1ps
module nand_op_seq_tb_top;
  localparam int LOADC = 40;
  localparam int POLLC = 8;
  localparam int LOGSZ = 2300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic [23:0] reqRow = '0;
  logic [11:0] reqCol = '0;
  logic [11:0] reqLen = '0;
  logic        chipSel = 1'b1;
  logic        busy, done, wrReady, rdValid;
  logic [1:0]  result;
  logic [7:0]  wrData, rdData, nandIoOut, nandIoIn;
  logic        nandCeN, nandCle, nandAle, nandWeN, nandReN, nandIoOe;

  nand_op_seq #(.LOAD_CYCLES(LOADC), .POLL_LIMIT(POLLC)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqRow(reqRow),
    .reqCol(reqCol), .reqLen(reqLen), .chipSel(chipSel), .busy(busy), .done(done),
    .result(result), .wrData(wrData), .wrReady(wrReady), .rdData(rdData),
    .rdValid(rdValid), .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandIoOut(nandIoOut), .nandIoOe(nandIoOe),
    .nandIoIn(nandIoIn)
  );

  int nChecks = 0, nFail = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pageByte(input logic [11:0] c);
    return c[7:0] ^ {c[11:8], c[11:8]} ^ 8'hA5;
  endfunction
  function automatic logic [7:0] idByte(input int i);
    case (i)
      0: return 8'h3C; 1: return 8'hD1; 2: return 8'h22; 3: return 8'h96; default: return 8'h4B;
    endcase
  endfunction
  function automatic logic [7:0] wrPat(input int i);
    return 8'(i * 7 + 13);
  endfunction

  // device model
  logic [9:0]  logQ [LOGSZ];
  logic [9:0]  expQ [LOGSZ];
  logic [7:0]  rdBuf [LOGSZ];
  int logN = 0, expN = 0, readN = 0, rdN = 0, wrIdx = 0;
  int modeM = 0, idPtr = 0, addrCnt = 0, busyLeft = 0, stallReads = 0;
  logic [11:0] colPtr = '0;
  logic failBit = 1'b0;
  int cyc = 0, t30 = 0, tRd = -1;
  bit doneSeen = 0, ceLowSeen = 0;
  logic [1:0] resSeen = '0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (wrReady) wrIdx <= wrIdx + 1;
  assign wrData = wrPat(wrIdx);
  assign nandIoIn = (modeM == 1) ? idByte(idPtr) :
                    (modeM == 2) ? ((busyLeft > 0) ? 8'h00 : {6'b010000, 1'b0, failBit}) :
                    pageByte(colPtr);

  always @(posedge nandWeN) if (rstN) begin
    if (logN < LOGSZ) logQ[logN] = {nandCle ? 2'd1 : nandAle ? 2'd2 : 2'd3, nandIoOut};
    logN++;
    if (nandCle) begin
      addrCnt = 0;
      case (nandIoOut)
        8'h90: begin modeM = 1; idPtr = 0; end
        8'h70: modeM = 2;
        8'h10, 8'hD0: busyLeft = stallReads;
        8'h30: begin modeM = 0; t30 = cyc; end
        default: ;
      endcase
    end else if (nandAle) begin
      if (addrCnt == 0) colPtr[7:0] = nandIoOut;
      else if (addrCnt == 1) colPtr[11:8] = nandIoOut[3:0];
      addrCnt++;
    end
  end
  always @(posedge nandReN) if (rstN) begin
    readN++;
    case (modeM)
      0: colPtr = colPtr + 12'd1;
      1: idPtr++;
      default: if (busyLeft > 0) busyLeft--;
    endcase
  end
  always @(negedge nandReN) if (rstN && tRd < 0) tRd = cyc;

  always @(negedge clk) begin
    if (rdValid) begin if (rdN < LOGSZ) rdBuf[rdN] = rdData; rdN++; end
    if (done) begin doneSeen = 1; resSeen = result; end
    if (!nandCeN) ceLowSeen = 1;
  end

  task automatic push(input logic [1:0] t, input logic [7:0] b);
    expQ[expN] = {t, b}; expN++;
  endtask
  task automatic pushAddr5(input logic [23:0] row, input logic [11:0] col);
    push(2, col[7:0]); push(2, {4'h0, col[11:8]});
    push(2, row[7:0]); push(2, row[15:8]); push(2, row[23:16]);
  endtask
  task automatic buildSeq(input int op, input logic [23:0] row, input logic [11:0] col, input int len);
    expN = 0;
    case (op)
      0: begin push(1, 8'h90); push(2, 8'h00); end
      1: begin push(1, 8'h00); pushAddr5(row, col); push(1, 8'h30); end
      2: begin
        push(1, 8'h80); pushAddr5(row, col);
        for (int i = 0; i < len; i++) push(3, wrPat(i));
        push(1, 8'h10); push(1, 8'h70);
      end
      3: begin
        push(1, 8'h60); push(2, {row[7:6], 6'b0}); push(2, row[15:8]); push(2, row[23:16]);
        push(1, 8'hD0); push(1, 8'h70);
      end
      default: push(1, 8'h70);
    endcase
  endtask

  task automatic runOp(input int op, input logic [23:0] row, input logic [11:0] col,
                       input int len, input bit sel, input string req);
    int bad;
    buildSeq(op, row, col, len);
    @(negedge clk);
    logN = 0; readN = 0; rdN = 0; wrIdx = 0; doneSeen = 0; tRd = -1; ceLowSeen = 0;
    reqValid = 1; reqOp = 3'(op); reqRow = row; reqCol = col; reqLen = 12'(len); chipSel = sel;
    @(negedge clk);
    reqValid = 0;
    repeat (2) @(negedge clk);
    // R1: request while busy must be ignored
    reqValid = 1; reqOp = 3'd0; reqRow = 24'hFFFFFF; reqCol = 12'hFFF;
    @(negedge clk);
    reqValid = 0;
    for (int w = 0; w < 20000 && !doneSeen; w++) @(negedge clk);
    chk(doneSeen, req, "done seen", int'(doneSeen), 1);
    @(negedge clk);
    chk(!busy, "R1", "busy after done", int'(busy), 0);
    chk(logN == expN, req, "bus cycle count", logN, expN);
    bad = 0;
    for (int i = 0; i < expN && i < logN; i++) if (logQ[i] !== expQ[i]) bad++;
    chk(bad == 0, req, "bus cycle mismatches", bad, 0);
  endtask

  initial begin
    #(200000 * 5);
    nFail++; nChecks++;
    $display("FAIL watchdog: actual 0 expected 1 completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int op, len, col, row;
    repeat (3) @(negedge clk);
    chk(nandWeN && nandReN && nandCeN && !nandCle && !nandAle && !nandIoOe && !busy,
        "R11", "reset pin state", int'({nandWeN, nandReN, nandCeN, nandCle, nandAle, nandIoOe, busy}), 7'b1110000);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk(nandWeN && nandReN && nandCeN && !busy, "R11", "idle after reset", int'(busy), 0);

    // R8 read ID
    runOp(0, 0, 0, 0, 1, "R8");
    chk(rdN == 5, "R8", "id bytes", rdN, 5);
    for (int i = 0; i < 5; i++) chk(rdBuf[i] == idByte(i), "R8", "id byte", rdBuf[i], idByte(i));
    chk(resSeen == 0, "R8", "result", resSeen, 0);
    chk(ceLowSeen, "R12", "ce low when selected", int'(ceLowSeen), 1);

    // R9 status op
    failBit = 1; stallReads = 0; busyLeft = 0;
    runOp(4, 0, 0, 0, 1, "R9");
    chk(rdN == 1 && rdBuf[0] == 8'h41, "R9", "status byte", rdBuf[0], 8'h41);
    chk(resSeen == 0, "R9", "result", resSeen, 0);

    // R3 spare-area read at column 2048
    runOp(1, 24'h012345, 12'd2048, 8, 1, "R3");
    chk(rdN == 8, "R3", "read count", rdN, 8);
    for (int i = 0; i < 8; i++)
      chk(rdBuf[i] == pageByte(12'(2048 + i)), "R3", "spare byte", rdBuf[i], pageByte(12'(2048 + i)));
    chk(tRd - t30 == LOADC + 1, "R3", "load wait", tRd - t30, LOADC + 1);

    // R4 full page program, R6 pass after stalls
    failBit = 0; stallReads = 2;
    runOp(2, 24'h00ABCD, 12'd0, 2112, 1, "R4");
    chk(resSeen == 0, "R6", "program result", resSeen, 0);
    chk(readN == 3, "R6", "poll reads", readN, 3);

    // R5 erase masks page bits, R6 fail flag
    failBit = 1; stallReads = 4;
    runOp(3, 24'h00ABFF, 12'd0, 0, 1, "R5");
    chk(resSeen == 1, "R6", "erase fail result", resSeen, 1);
    chk(readN == 5, "R6", "poll reads", readN, 5);

    // R7 timeout
    failBit = 0; stallReads = 100;
    runOp(2, 24'h000040, 12'd5, 1, 1, "R7");
    chk(resSeen == 2, "R7", "timeout result", resSeen, 2);
    chk(readN == POLLC, "R7", "poll reads", readN, POLLC);

    // R12 deselected chip
    runOp(1, 24'h000001, 12'd0, 2, 0, "R12");
    chk(!ceLowSeen, "R12", "ce stays high", int'(ceLowSeen), 0);

    // random mix
    void'($urandom(32'd20240607));
    for (int k = 0; k < 8; k++) begin
      op = 1 + int'($urandom % 3);
      len = 1 + int'($urandom % 24);
      col = int'($urandom % 2112);
      row = int'($urandom & 32'h00FFFFFF);
      stallReads = int'($urandom % 5);
      failBit = 1'($urandom);
      runOp(op, 24'(row), 12'(col), len, 1, op == 1 ? "R3" : op == 2 ? "R4" : "R5");
      if (op == 1) begin
        chk(rdN == len, "R3", "random read count", rdN, len);
        for (int i = 0; i < len; i++)
          chk(rdBuf[i] == pageByte(12'(col + i)), "R3", "random data", rdBuf[i], pageByte(12'(col + i)));
      end else begin
        chk(resSeen == 2'(failBit), "R6", "random result", resSeen, int'(failBit));
        chk(readN == stallReads + 1, "R6", "random poll reads", readN, stallReads + 1);
      end
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule